// File: doc/BRIEF.md
# Programmable-Flag FIFO Controller

A single-clock first-in first-out buffer with a complete set of fill-level indicators. Besides empty, full and half-full, it raises almost-empty and almost-full warnings against two programmable offsets. After a master reset each offset takes one of eight preset values, chosen by a 3-bit select input. Either offset can later be rewritten as a whole word through a parallel load port, or both can be rewritten together through a one-bit serial stream.

A mode input is captured at master reset and picks one of two read styles, which stays fixed until the next master reset. In standard style a read request is needed before a word reaches the registered output, and the two main flags mean "empty" and "full". In fall-through style the oldest word is shown on the output without any request, and the same two flags mean "output ready" and "input ready". A retransmit pulse rewinds reading to the first word written since reset. A partial reset drops all stored data but keeps the offsets and the read style.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_n` is low on a clock edge, the buffer is emptied, `rd_data` becomes 0, `fwft_pin` is captured as the read style, and both offsets are set to the preset picked by `dflt_sel`.
- R2: The fill count is the number of accepted writes minus accepted reads. `half_full` is 1 exactly when the count exceeds DEPTH/2. In standard style `empty_or` is 1 when the count is 0, and `full_ir` is 1 when the count equals DEPTH.
- R3: A write while the count equals DEPTH is dropped. A read while the count is 0 is dropped. Neither moves a pointer or changes `rd_data`.
- R4: In standard style, an accepted read loads the oldest stored word into `rd_data` on that clock edge. Words come out in write order. `rd_data` holds its value when no read is accepted.
- R5: In fall-through style, `rd_data` shows the oldest stored word whenever the count is nonzero, and shows 0 otherwise. `empty_or` is 1 when the count is nonzero. `full_ir` is 1 when the count is below DEPTH. An accepted read moves to the next word.
- R6: `almost_empty` is 1 exactly when the count is at or below the empty offset.
- R7: `almost_full` is 1 exactly when DEPTH minus the count is at or below the full offset.
- R8: Preset offset for select value s (0..7) is 2^(s+3)-1: 7, 15, 31, 63, 127, 255, 511 or 1023.
- R9: With `ld_en` high on a clock edge, `ld_data` replaces the empty offset when `ld_sel`=0, or the full offset when `ld_sel`=1. The parallel load wins over a serial load in the same cycle.
- R10: Each clock with `ser_en` high and `ld_en` low shifts `ser_bit` into a 2*OFS_W-bit chain. After 2*OFS_W bits, bit k of the stream (k from 0) is bit k of the empty offset for k < OFS_W, and bit k-OFS_W of the full offset otherwise.
- R11: With `rst_n` high and `prst_n` low on a clock edge, the count becomes 0, the pointers rewind and `rd_data` becomes 0, while both offsets and the read style are kept.
- R12: A `rt` pulse (with no reset) sets the read position to the first word written since the last reset. The count becomes the number of words written since then, as long as that is at most DEPTH. Reads and writes in that cycle are dropped. The very next read, or at once in fall-through style, returns the first word.
- R13: The read style changes only during master reset. `fwft_pin` has no effect at any other time, including during a partial reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| fwft_pin | input | 1 | Read style captured at master reset: 1 = fall-through |
| dflt_sel | input | 3 | Preset offset select captured at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word |
| rt | input | 1 | Retransmit pulse |
| ser_en | input | 1 | Serial offset shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| ld_en | input | 1 | Parallel offset load enable |
| ld_sel | input | 1 | Parallel target: 0 empty offset, 1 full offset |
| ld_data | input | OFS_W | Parallel offset value |
| empty_or | output | 1 | Empty (standard) or output ready (fall-through) |
| full_ir | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Count above DEPTH/2 |
| almost_empty | output | 1 | Count at or below empty offset |
| almost_full | output | 1 | Free space at or below full offset |

## Verification
The corners that are hardest to reach sit at the very top of the buffer. These are the almost-full threshold with offsets only a few words wide, the full boundary, and a write attempt while full. The stimulus reaches them by streaming more than a thousand back-to-back writes, with the threshold first set small by a parallel or serial load. It then drains every word to prove the dropped write left no trace. Retransmit is checked in both read styles after a partial drain. Keeping the read style across a partial reset is shown by toggling the mode pin during that reset and reading the flag polarity afterwards.

// File: rtl/pff_pkg.sv
// Shared helpers for the programmable-flag FIFO.
// Assumes the select input is 3 bits wide, giving eight presets.
package pff_pkg;
    // Preset threshold for a select code: 2^(sel+3)-1.
    function automatic logic [15:0] preset_offset(input logic [2:0] sel);
        return 16'((32'd1 << (32'(sel) + 32'd3)) - 32'd1);
    endfunction
endpackage

// File: rtl/pff_cfg.sv
// Offset and read-style configuration.
// Holds the empty and full offsets and the captured read style.
// Assumes rst_n is the master reset; partial reset never reaches this block.
module pff_cfg
    import pff_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwft_pin,
    input  logic [2:0]       dflt_sel,
    input  logic             ser_en,
    input  logic             ser_bit,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [OFS_W-1:0] ld_data,
    output logic             fwft,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam int CHAIN_W = 2 * OFS_W;

    logic [CHAIN_W-1:0] chain_q;
    logic [OFS_W-1:0]   preset;

    assign preset = OFS_W'(preset_offset(dflt_sel));
    assign ae_ofs = chain_q[OFS_W-1:0];
    assign af_ofs = chain_q[CHAIN_W-1:OFS_W];

    // Capture the read style only while master reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) fwft <= fwft_pin;
    end

    // Offset chain: preset on reset, parallel load first, else serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {preset, preset};
        end else if (ld_en) begin
            if (ld_sel) chain_q[CHAIN_W-1:OFS_W] <= ld_data;
            else        chain_q[OFS_W-1:0]       <= ld_data;
        end else if (ser_en) begin
            chain_q <= {ser_bit, chain_q[CHAIN_W-1:1]};
        end
    end

    // R13: the read style is frozen outside master reset.
    a_r13_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(fwft));

    // R9: a parallel load lands in the chosen half.
    a_r9_parallel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !ld_sel) |=> (ae_ofs == $past(ld_data)));
endmodule

// File: rtl/pff_store.sv
// Storage array, pointers, fill count and read register.
// Assumes DEPTH = 2**AW so the pointers wrap on their own. Master reset
// and partial reset both clear the state here; retransmit rewinds the
// read side to the first word written since reset.
module pff_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    parameter int AW     = 10,
    parameter int CW     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              fwft,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rt,
    output logic [CW-1:0]     count,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt, wr_total;
    logic [DATA_W-1:0] dout_q;
    logic              run, wr_ok, rd_ok;

    assign run   = rst_n && prst_n && !rt;
    assign wr_ok = run && wr_en && (cnt != FULL_CNT);
    assign rd_ok = run && rd_en && (cnt != '0);
    assign count = cnt;

    // Write port into the array.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Pointer, count and history updates with reset and rewind priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            wr_total <= '0;
        end else if (rt) begin
            rd_ptr <= '0;
            cnt    <= wr_total;
        end else begin
            if (wr_ok) wr_ptr <= AW'(wr_ptr + 1'b1);
            if (rd_ok) rd_ptr <= AW'(rd_ptr + 1'b1);
            if (wr_ok && (wr_total != FULL_CNT)) wr_total <= CW'(wr_total + 1'b1);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= CW'(cnt + 1'b1);
                2'b01:   cnt <= CW'(cnt - 1'b1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Standard-style output register, loaded on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) dout_q <= '0;
        else if (rd_ok && !fwft) dout_q <= mem[rd_ptr];
    end

    // Output select: head word in fall-through style, register otherwise.
    always_comb begin
        if (fwft) rd_data = (cnt != '0) ? mem[rd_ptr] : '0;
        else      rd_data = dout_q;
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !rt && $past(rst_n)) |=> ((cnt == $past(cnt)) ||
            (cnt == CW'($past(cnt) + 1'b1)) || (cnt == CW'($past(cnt) - 1'b1))));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !rt && wr_en && !rd_en && cnt == FULL_CNT) |=> $stable(wr_ptr));

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !rt && rd_en && cnt == '0) |=> $stable(rd_ptr));

    a_r11_partial_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> (cnt == '0 && rd_ptr == '0 && wr_ptr == '0));

    a_r12_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (rt && prst_n) |=> (rd_ptr == '0));
endmodule

// File: rtl/pff_flags.sv
// Fill-level indicators derived from the count and the two offsets.
// Pure combinational; flag polarity of the two main flags follows the
// read style: empty/full in standard style, ready flags in fall-through.
module pff_flags #(
    parameter int DEPTH = 1024,
    parameter int CW    = 11,
    parameter int OFS_W = 10
) (
    input  logic [CW-1:0]    count,
    input  logic             fwft,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             empty_or,
    output logic             full_ir,
    output logic             half_full,
    output logic             almost_empty,
    output logic             almost_full
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic          is_empty, is_full;
    logic [CW-1:0] free_cnt;

    // Level decode and threshold compares.
    always_comb begin
        is_empty     = (count == '0);
        is_full      = (count == FULL_CNT);
        free_cnt     = CW'(FULL_CNT - count);
        empty_or     = fwft ? !is_empty : is_empty;
        full_ir      = fwft ? !is_full  : is_full;
        half_full    = (count > HALF_CNT);
        almost_empty = (count <= CW'(ae_ofs));
        almost_full  = (free_cnt <= CW'(af_ofs));
    end
endmodule

// File: rtl/pflag_fifo.sv
// Programmable-flag FIFO top level.
// One clock drives both ports. Priority: master reset, partial reset,
// retransmit, then normal reads and writes. DEPTH must be a power of two
// and the offset width must not exceed the count width.
module pflag_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    parameter int OFS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              fwft_pin,
    input  logic [2:0]        dflt_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rt,
    input  logic              ser_en,
    input  logic              ser_bit,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [OFS_W-1:0]  ld_data,
    output logic              empty_or,
    output logic              full_ir,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic             fwft;
    logic [OFS_W-1:0] ae_ofs, af_ofs;
    logic [CW-1:0]    count;

    pff_cfg #(.OFS_W(OFS_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .fwft_pin(fwft_pin), .dflt_sel(dflt_sel),
        .ser_en(ser_en), .ser_bit(ser_bit), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_data(ld_data), .fwft(fwft), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    pff_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .fwft(fwft),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rt(rt),
        .count(count), .rd_data(rd_data)
    );

    pff_flags #(.DEPTH(DEPTH), .CW(CW), .OFS_W(OFS_W)) u_flags (
        .count(count), .fwft(fwft), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .empty_or(empty_or), .full_ir(full_ir), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // R11: partial reset leaves both offsets untouched.
    a_r11_offsets_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!prst_n && !ld_en && !ser_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

    // R5: in fall-through style, output ready tracks a nonzero count.
    a_r5_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fwft |-> (empty_or == (count != '0)));
endmodule

// File: tb/pflag_fifo_bench.sv
`timescale 1ns/1ps
module pflag_fifo_bench;
    localparam int DW = 8;
    localparam int DEPTH = 1024;
    localparam int OW = 10;

    logic clk = 0;
    logic rst_n = 0, prst_n = 1, fwft_pin = 0;
    logic [2:0] dflt_sel = 0;
    logic wr_en = 0, rd_en = 0, rt = 0, ser_en = 0, ser_bit = 0, ld_en = 0, ld_sel = 0;
    logic [DW-1:0] wr_data = 0;
    logic [OW-1:0] ld_data = 0;
    logic [DW-1:0] rd_data;
    logic empty_or, full_ir, half_full, almost_empty, almost_full;

    int checks = 0, fails = 0, cycles = 0;
    logic [DW-1:0] hist[$];
    int rd_idx = 0;

    always #10 clk = ~clk;

    pflag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .OFS_W(OW)) u_pflag_fifo (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .fwft_pin(fwft_pin),
        .dflt_sel(dflt_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rt(rt), .ser_en(ser_en), .ser_bit(ser_bit),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .empty_or(empty_or), .full_ir(full_ir), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int level();
        return hist.size() - rd_idx;
    endfunction

    task automatic mreset(input logic style, input logic [2:0] sel);
        rst_n = 0; fwft_pin = style; dflt_sel = sel;
        @(negedge clk); @(negedge clk);
        rst_n = 1; fwft_pin = ~style;
        hist.delete(); rd_idx = 0;
    endtask

    task automatic push_word();
        logic [DW-1:0] d;
        d = DW'(hist.size() * 29 + 3);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        hist.push_back(d);
    endtask

    task automatic fill_to(input int n);
        while (level() < n) push_word();
    endtask

    task automatic pop_std(input string req);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        check(req, rd_data, hist[rd_idx]);
        rd_idx++;
    endtask

    task automatic t_reset_state();
        mreset(0, 0);
        check("R1 empty", empty_or, 1);
        check("R1 full", full_ir, 0);
        check("R1 half", half_full, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 ae", almost_empty, 1);
        check("R1 af", almost_full, 0);
    endtask

    task automatic t_fill_drain();
        logic [DW-1:0] last;
        mreset(0, 0);
        fill_to(7);  check("R8 R6 ae at 7", almost_empty, 1);
        fill_to(8);  check("R8 R6 ae at 8", almost_empty, 0);
        check("R2 not empty", empty_or, 0);
        fill_to(512); check("R2 half at 512", half_full, 0);
        fill_to(513); check("R2 half at 513", half_full, 1);
        fill_to(1016); check("R7 af free 8", almost_full, 0);
        fill_to(1017); check("R7 af free 7", almost_full, 1);
        fill_to(1023); check("R2 full at 1023", full_ir, 0);
        fill_to(1024); check("R2 full at 1024", full_ir, 1);
        wr_en = 1; wr_data = 8'hEE; @(negedge clk); wr_en = 0;
        check("R3 still full", full_ir, 1);
        pop_std("R4 first");
        @(negedge clk);
        check("R4 hold", rd_data, hist[rd_idx-1]);
        for (int i = 1; i < 1024; i++) pop_std("R4 R3 order");
        check("R2 empty after drain", empty_or, 1);
        last = rd_data;
        rd_en = 1; @(negedge clk); rd_en = 0;
        check("R3 empty read", rd_data, last);
        check("R3 still empty", empty_or, 1);
        push_word();
        pop_std("R3 pointer kept");
    endtask

    task automatic t_parallel();
        mreset(0, 0);
        ld_en = 1; ld_sel = 0; ld_data = 3; ser_en = 1; ser_bit = 1;
        @(negedge clk);
        ld_sel = 1; ld_data = 2;
        @(negedge clk);
        ld_en = 0; ser_en = 0;
        fill_to(3); check("R9 ae at 3", almost_empty, 1);
        fill_to(4); check("R9 ae at 4", almost_empty, 0);
        fill_to(1021); check("R9 af free 3", almost_full, 0);
        fill_to(1022); check("R9 af free 2", almost_full, 1);
    endtask

    task automatic t_serial_partial();
        logic [2*OW-1:0] stream;
        mreset(0, 0);
        stream = {10'd9, 10'd5};
        ser_en = 1;
        for (int i = 0; i < 2*OW; i++) begin
            ser_bit = stream[i];
            @(negedge clk);
        end
        ser_en = 0;
        fill_to(5); check("R10 ae at 5", almost_empty, 1);
        fill_to(6); check("R10 ae at 6", almost_empty, 0);
        fill_to(1014); check("R10 af free 10", almost_full, 0);
        fill_to(1015); check("R10 af free 9", almost_full, 1);
        pop_std("R4 before partial");
        prst_n = 0; @(negedge clk); prst_n = 1;
        hist.delete(); rd_idx = 0;
        check("R11 empty", empty_or, 1);
        check("R11 rd_data", rd_data, 0);
        check("R11 mode kept", full_ir, 0);
        fill_to(5); check("R11 ae kept at 5", almost_empty, 1);
        fill_to(6); check("R11 ae kept at 6", almost_empty, 0);
    endtask

    task automatic t_retransmit_std();
        mreset(0, 0);
        fill_to(4);
        pop_std("R4 rt pre0");
        pop_std("R4 rt pre1");
        rt = 1; @(negedge clk); rt = 0;
        check("R12 rd_data kept", rd_data, hist[1]);
        rd_idx = 0;
        pop_std("R12 first word");
        pop_std("R12 second word");
    endtask

    task automatic t_fwft();
        mreset(1, 3);
        check("R5 not ready", empty_or, 0);
        check("R5 input ready", full_ir, 1);
        check("R5 zero out", rd_data, 0);
        push_word();
        check("R5 fall through", rd_data, hist[0]);
        check("R5 ready", empty_or, 1);
        rd_en = 1; @(negedge clk); rd_en = 0; rd_idx++;
        check("R5 emptied", empty_or, 0);
        push_word(); push_word();
        check("R5 head", rd_data, hist[1]);
        rd_en = 1; @(negedge clk); rd_en = 0; rd_idx++;
        check("R5 next head", rd_data, hist[2]);
        rt = 1; @(negedge clk); rt = 0; rd_idx = 0;
        check("R12 fwft rewind", rd_data, hist[0]);
        prst_n = 0; fwft_pin = 0; @(negedge clk); prst_n = 1; fwft_pin = 1;
        hist.delete(); rd_idx = 0;
        check("R13 style kept ready", empty_or, 0);
        check("R13 style kept ir", full_ir, 1);
        fill_to(63); check("R8 sel3 ae at 63", almost_empty, 1);
        fill_to(64); check("R8 sel3 ae at 64", almost_empty, 0);
    endtask

    initial begin
        t_reset_state();
        t_fill_drain();
        t_parallel();
        t_serial_partial();
        t_retransmit_std();
        t_fwft();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule